// File: doc/BRIEF.md
# Memory-fed PWM sequence player

This block drives three PWM outputs from a list of 16-bit samples held in memory. A single start pulse captures the configuration and begins playback. The block then walks the list through a request/grant read port, one step at a time. Each step is one record of one, two or four words. The word mode decides how the words of a record map onto the three channels. In the four-word mode the record also sets the period of its own step.

Within a step, a 15-bit up-counter advances once per prescaled tick. It runs from zero to the top value and wraps. Each channel compares the counter against its own sample. The whole list is played a programmed number of passes. After the last count of the last period, a one-cycle finished pulse is raised and the outputs go back to low. While a record is being fetched, including any cycles where the grant is withheld, the outputs keep their last level.

Top module: `pwm_seq_player`

## Requirements
- R1: After reset, `pwm_out` is 0, `rd_req` is 0 and `done` is 0.
- R2: A sample uses bit 15 as the polarity flag and bits 14:0 as the compare value. With polarity 0, a channel is high while the counter is below the compare value and low otherwise. Polarity 1 inverts this.
- R3: During a step, the counter holds each value from 0 to top for 2^`cfg_presc` clock cycles. A step therefore runs (top+1)·2^`cfg_presc` cycles after its record is fetched.
- R4: With `cfg_mode` 0 (and 3, which behaves the same way), each record is one word. That word drives all three channels, and the top value is `cfg_top`.
- R5: With `cfg_mode` 1, each record is two words. Word 0 drives channels 0 and 1, word 1 drives channel 2, and the top value is `cfg_top`.
- R6: With `cfg_mode` 2, each record is four words. Words 0 to 2 drive channels 0 to 2, and bits 14:0 of word 3 replace the top value for that step.
- R7: Reads start at `cfg_base`, and the address rises by one for each granted word. A pass reads floor(`cfg_count` / record size) whole records, and the leftover words are never read. Each pass starts again at `cfg_base`. The number of passes is `cfg_loops`, and a value of 0 counts as one pass.
- R8: A compare value above the top value keeps the channel at one constant level for the whole step: high with polarity 0, low with polarity 1.
- R9: `rd_req` stays high with a stable `rd_addr` until `rd_gnt` is seen. `pwm_out` does not change during any cycle in which `rd_req` is high.
- R10: `done` is a single-cycle pulse. It is raised in the cycle after the last counter value of the last step, and `pwm_out` is 0 from that cycle on. The time from start to `done` is the sum of the fetch cycles and step cycles, plus one.
- R11: If `cfg_count` is smaller than one record, `done` pulses in the cycle after start and no read is made.
- R12: A start pulse during playback is ignored, and changes to any `cfg_*` input after start have no effect on the current playback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins playback |
| cfg_mode | input | 2 | Word mode: 0 one word, 1 two words, 2 four words with period, 3 as 0 |
| cfg_presc | input | PRE_W | Clock divide exponent: tick every 2^n cycles |
| cfg_top | input | 15 | Counter top value for modes 0, 1 and 3 |
| cfg_base | input | ADDR_W | Word address of the first record |
| cfg_count | input | LEN_W | Number of words in the list |
| cfg_loops | input | LOOP_W | Number of passes over the list (0 means 1) |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Word address of the read |
| rd_gnt | input | 1 | Grant; `rd_data` is valid in the same cycle |
| rd_data | input | 16 | Read data |
| pwm_out | output | 3 | Channel outputs |
| done | output | 1 | One-cycle finished pulse |

## Verification
Some properties are checked by the assertions on every cycle:
- an ungranted request persists with its address unchanged;
- the outputs are frozen while a read is pending;
- `done` lasts one cycle and coincides with low outputs and no request;
- the counter never passes the top value of the current step.

Other behaviour can only be shown by whole playbacks in the bench scenarios:
- the correct word-to-channel mapping in each mode;
- the per-step period;
- the polarity and over-top levels;
- dropping of leftover words, restart at the base address on each pass, and ignoring of a second start.

These scenarios compare the high time counted on each channel and the total run time against a model fed by the observed fetch cycles.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;

  localparam int SAMPLE_W  = 16;
  localparam int CMP_W     = 15;
  localparam int NUM_CH    = 3;
  localparam int MAX_WORDS = 4;

  typedef enum logic [1:0] {
    MODE_COMMON  = 2'd0,
    MODE_GROUPED = 2'd1,
    MODE_WAVE    = 2'd2,
    MODE_ALT     = 2'd3
  } seq_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RUN   = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic             pol;
    logic [CMP_W-1:0] cmp;
  } sample_t;

  // log2 of the record size in words
  function automatic logic [1:0] rec_shift(seq_mode_e m);
    case (m)
      MODE_GROUPED: rec_shift = 2'd1;
      MODE_WAVE:    rec_shift = 2'd2;
      default:      rec_shift = 2'd0;
    endcase
  endfunction

  // index of the last word in a record
  function automatic logic [1:0] rec_last(seq_mode_e m);
    case (m)
      MODE_GROUPED: rec_last = 2'd1;
      MODE_WAVE:    rec_last = 2'd3;
      default:      rec_last = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/pwm_seq_prescale.sv
module pwm_seq_prescale #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PRE_W-1:0] sel,
  output logic             tick
);

  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] div_q, div_d, lim;

  assign lim  = ~({DIV_W{1'b1}} << sel);
  assign tick = en && (div_q == lim);

  always_comb begin
    div_d = div_q;
    if (!en || tick) div_d = '0;
    else             div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R3
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (div_q <= lim));

endmodule

// File: rtl/pwm_seq_chan.sv
module pwm_seq_chan
  import pwm_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic [CMP_W-1:0] cnt,
  input  sample_t          smp,
  output logic             out
);

  logic out_q, out_d;

  always_comb begin
    out_d = out_q;
    if (clr)      out_d = 1'b0;
    else if (upd) out_d = (cnt < smp.cmp) ^ smp.pol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign out = out_q;

endmodule

// File: rtl/pwm_seq_player.sv
module pwm_seq_player
  import pwm_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8,
  parameter int LOOP_W = 8,
  parameter int PRE_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [1:0]          cfg_mode,
  input  logic [PRE_W-1:0]    cfg_presc,
  input  logic [CMP_W-1:0]    cfg_top,
  input  logic [ADDR_W-1:0]   cfg_base,
  input  logic [LEN_W-1:0]    cfg_count,
  input  logic [LOOP_W-1:0]   cfg_loops,
  output logic                rd_req,
  output logic [ADDR_W-1:0]   rd_addr,
  input  logic                rd_gnt,
  input  logic [SAMPLE_W-1:0] rd_data,
  output logic [NUM_CH-1:0]   pwm_out,
  output logic                done
);

  seq_state_e          state_q, state_d;
  seq_mode_e           mode_q, mode_d;
  logic [PRE_W-1:0]    presc_q, presc_d;
  logic [CMP_W-1:0]    top_cfg_q, top_cfg_d;
  logic [CMP_W-1:0]    top_q, top_d;
  logic [CMP_W-1:0]    cnt_q, cnt_d;
  logic [ADDR_W-1:0]   base_q, base_d, addr_q, addr_d;
  logic [LEN_W-1:0]    steps_cfg_q, steps_cfg_d, steps_q, steps_d;
  logic [LOOP_W-1:0]   loops_q, loops_d;
  logic [1:0]          widx_q, widx_d;
  logic [SAMPLE_W-1:0] buf_q [MAX_WORDS];
  logic [SAMPLE_W-1:0] wv    [MAX_WORDS];
  sample_t             smp_q [NUM_CH];
  sample_t             smp_d [NUM_CH];
  logic                done_q, done_d;
  logic                buf_we, step_load, run_en, out_clr, tick;
  logic [LEN_W-1:0]    stp_new;

  assign stp_new = cfg_count >> rec_shift(seq_mode_e'(cfg_mode));
  assign buf_we  = (state_q == ST_FETCH) && rd_gnt;

  // record words with the word arriving this cycle merged in
  always_comb begin
    for (int k = 0; k < MAX_WORDS; k++)
      wv[k] = (widx_q == 2'(k)) ? rd_data : buf_q[k];
  end

  // record decode per word mode
  always_comb begin
    top_d = top_cfg_q;
    case (mode_q)
      MODE_GROUPED: begin
        smp_d[0] = sample_t'(wv[0]);
        smp_d[1] = sample_t'(wv[0]);
        smp_d[2] = sample_t'(wv[1]);
      end
      MODE_WAVE: begin
        for (int k = 0; k < NUM_CH; k++) smp_d[k] = sample_t'(wv[k]);
        top_d = wv[3][CMP_W-1:0];
      end
      default: begin
        for (int k = 0; k < NUM_CH; k++) smp_d[k] = sample_t'(wv[0]);
      end
    endcase
  end

  // sequencing
  always_comb begin
    state_d     = state_q;
    mode_d      = mode_q;
    presc_d     = presc_q;
    top_cfg_d   = top_cfg_q;
    base_d      = base_q;
    steps_cfg_d = steps_cfg_q;
    steps_d     = steps_q;
    loops_d     = loops_q;
    addr_d      = addr_q;
    widx_d      = widx_q;
    cnt_d       = cnt_q;
    done_d      = 1'b0;
    step_load   = 1'b0;
    run_en      = 1'b0;
    out_clr     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        out_clr = 1'b1;
        if (start) begin
          mode_d      = seq_mode_e'(cfg_mode);
          presc_d     = cfg_presc;
          top_cfg_d   = cfg_top;
          base_d      = cfg_base;
          steps_cfg_d = stp_new;
          addr_d      = cfg_base;
          widx_d      = '0;
          steps_d     = stp_new - 1'b1;
          loops_d     = (cfg_loops == '0) ? '0 : cfg_loops - 1'b1;
          if (stp_new == '0) done_d  = 1'b1;
          else               state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (rd_gnt) begin
          addr_d = addr_q + 1'b1;
          if (widx_q == rec_last(mode_q)) begin
            widx_d    = '0;
            step_load = 1'b1;
            cnt_d     = '0;
            state_d   = ST_RUN;
          end else begin
            widx_d = widx_q + 1'b1;
          end
        end
      end
      ST_RUN: begin
        run_en = 1'b1;
        if (tick) begin
          if (cnt_q == top_q) begin
            if (steps_q != '0) begin
              steps_d = steps_q - 1'b1;
              state_d = ST_FETCH;
            end else if (loops_q != '0) begin
              loops_d = loops_q - 1'b1;
              steps_d = steps_cfg_q - 1'b1;
              addr_d  = base_q;
              state_d = ST_FETCH;
            end else begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
              out_clr = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      mode_q      <= MODE_COMMON;
      presc_q     <= '0;
      top_cfg_q   <= '0;
      base_q      <= '0;
      steps_cfg_q <= '0;
      steps_q     <= '0;
      loops_q     <= '0;
      addr_q      <= '0;
      widx_q      <= '0;
      cnt_q       <= '0;
      done_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      mode_q      <= mode_d;
      presc_q     <= presc_d;
      top_cfg_q   <= top_cfg_d;
      base_q      <= base_d;
      steps_cfg_q <= steps_cfg_d;
      steps_q     <= steps_d;
      loops_q     <= loops_d;
      addr_q      <= addr_d;
      widx_q      <= widx_d;
      cnt_q       <= cnt_d;
      done_q      <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < MAX_WORDS; k++) buf_q[k] <= '0;
    end else if (buf_we) begin
      buf_q[widx_q] <= rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '0;
      for (int k = 0; k < NUM_CH; k++) smp_q[k] <= '0;
    end else if (step_load) begin
      top_q <= top_d;
      for (int k = 0; k < NUM_CH; k++) smp_q[k] <= smp_d[k];
    end
  end

  pwm_seq_prescale #(.PRE_W(PRE_W)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (run_en),
    .sel  (presc_q),
    .tick (tick)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    pwm_seq_chan u_chan (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (out_clr),
      .upd  (run_en),
      .cnt  (cnt_q),
      .smp  (smp_q[g]),
      .out  (pwm_out[g])
    );
  end

  assign rd_req  = (state_q == ST_FETCH);
  assign rd_addr = addr_q;
  assign done    = done_q;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_gnt) |=> (rd_req && $stable(rd_addr)));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> $stable(pwm_out));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pwm_out == '0 && !rd_req));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (cnt_q <= top_q));

endmodule

// File: tb/pwm_seq_player_test.sv
module pwm_seq_player_test;
  import pwm_seq_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int MAXG       = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  cfg_mode;
  logic [2:0]  cfg_presc;
  logic [14:0] cfg_top;
  logic [15:0] cfg_base;
  logic [7:0]  cfg_count;
  logic [7:0]  cfg_loops;
  logic        rd_req;
  logic [15:0] rd_addr;
  logic        rd_gnt;
  logic [15:0] rd_data;
  logic [2:0]  pwm_out;
  logic        done;

  logic [15:0] mem [64];
  int fcyc [MAXG];
  int tests = 0;
  int fails = 0;
  int n_cyc, n_gnt, n_step, addr_err;
  int hi [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_seq_player uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
    .cfg_presc(cfg_presc), .cfg_top(cfg_top), .cfg_base(cfg_base),
    .cfg_count(cfg_count), .cfg_loops(cfg_loops), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_gnt(rd_gnt), .rd_data(rd_data),
    .pwm_out(pwm_out), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int words_of(int mode);
    return (mode == 1) ? 2 : (mode == 2) ? 4 : 1;
  endfunction

  function automatic int lev(logic [15:0] w, int c);
    return ((c < int'(w[14:0])) ? 1 : 0) ^ int'(w[15]);
  endfunction

  function automatic logic [15:0] step_word(int mode, int a, int ch);
    if (mode == 1) return (ch < 2) ? mem[a] : mem[a+1];
    if (mode == 2) return mem[a+ch];
    return mem[a];
  endfunction

  function automatic int step_top(int mode, int topc, int a);
    return (mode == 2) ? int'(mem[a+3][14:0]) : topc;
  endfunction

  function automatic int exp_high(int mode, int p, int topc, int base,
                                  int s_cnt, int passes, int ch);
    int h = 0;
    int prev = 0;
    int g = 0;
    for (int ps = 0; ps < passes; ps++) begin
      for (int j = 0; j < s_cnt; j++) begin
        int a = base + j * words_of(mode);
        logic [15:0] w = step_word(mode, a, ch);
        int t = step_top(mode, topc, a);
        int run = 0;
        for (int c = 0; c <= t; c++) run += lev(w, c);
        h += fcyc[g] * prev + (run << p);
        prev = lev(w, t);
        g++;
      end
    end
    return h - prev;
  endfunction

  function automatic int exp_dur(int mode, int p, int topc, int base,
                                 int s_cnt, int passes);
    int d = 1;
    int g = 0;
    for (int ps = 0; ps < passes; ps++) begin
      for (int j = 0; j < s_cnt; j++) begin
        int a = base + j * words_of(mode);
        d += fcyc[g] + ((step_top(mode, topc, a) + 1) << p);
        g++;
      end
    end
    return d;
  endfunction

  task automatic fill_mem(int mode, int base, int maxcmp);
    for (int a = 0; a < 64; a++) begin
      mem[a] = {1'($urandom % 2), 15'($urandom % maxcmp)};
      if (mode == 2 && a >= base && ((a - base) % 4) == 3)
        mem[a] = {1'($urandom % 2), 15'($urandom % 12)};
    end
  endtask

  task automatic run_seq(int mode, int p, int topc, int base, int count,
                         int loops, int stall, bit poke);
    int w = words_of(mode);
    int s_cnt = count / w;
    int passes = (loops == 0) ? 1 : loops;
    string rq = (mode == 2) ? "R6" : (mode == 1) ? "R5" : "R4";
    for (int g = 0; g < MAXG; g++) fcyc[g] = 0;
    n_cyc = 0; n_gnt = 0; n_step = 0; addr_err = 0;
    for (int k = 0; k < 3; k++) hi[k] = 0;
    @(negedge clk);
    cfg_mode  = 2'(mode);
    cfg_presc = 3'(p);
    cfg_top   = 15'(topc);
    cfg_base  = 16'(base);
    cfg_count = 8'(count);
    cfg_loops = 8'(loops);
    rd_gnt    = 1'b0;
    start     = 1'b1;
    @(posedge clk);
    forever begin
      @(negedge clk);
      start = 1'b0;
      n_cyc++;
      if (poke && n_cyc == 3) begin
        start     = 1'b1;
        cfg_mode  = ~cfg_mode;
        cfg_top   = cfg_top + 15'd7;
        cfg_base  = cfg_base + 16'd5;
        cfg_count = cfg_count + 8'd4;
        cfg_loops = cfg_loops + 8'd1;
        cfg_presc = cfg_presc + 3'd1;
      end
      for (int k = 0; k < 3; k++) hi[k] += int'(pwm_out[k]);
      rd_gnt = 1'b0;
      if (done || n_cyc > 60000) break;
      if (rd_req) begin
        if (n_step < MAXG) fcyc[n_step]++;
        if (stall == 0 || ($urandom % 3) != 0) begin
          rd_gnt  = 1'b1;
          rd_data = mem[rd_addr[5:0]];
          if (int'(rd_addr) != base + (n_gnt % (s_cnt * w))) addr_err++;
          n_gnt++;
          if ((n_gnt % w) == 0) n_step++;
        end
      end
    end
    start = 1'b0;
    if (s_cnt == 0) begin
      chk(n_cyc == 1, "R11", "cycles to done", n_cyc, 1);
      chk(n_gnt == 0, "R11", "reads made", n_gnt, 0);
    end else begin
      chk(addr_err == 0, "R7", "address mismatches", addr_err, 0);
      chk(n_gnt == s_cnt * passes * w, "R7", "words read", n_gnt, s_cnt * passes * w);
      chk(n_cyc == exp_dur(mode, p, topc, base, s_cnt, passes), "R3", "run length",
          n_cyc, exp_dur(mode, p, topc, base, s_cnt, passes));
      for (int k = 0; k < 3; k++)
        chk(hi[k] == exp_high(mode, p, topc, base, s_cnt, passes, k), rq, "high cycles",
            hi[k], exp_high(mode, p, topc, base, s_cnt, passes, k));
      if (poke)
        chk(n_gnt == s_cnt * passes * w, "R12", "reads after second start",
            n_gnt, s_cnt * passes * w);
    end
    @(negedge clk);
    chk(done == 1'b0, "R10", "done width", int'(done), 0);
    chk(pwm_out == 3'b000, "R10", "outputs after done", int'(pwm_out), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    rst_n = 1'b0; start = 1'b0; cfg_mode = '0; cfg_presc = '0; cfg_top = '0;
    cfg_base = '0; cfg_count = '0; cfg_loops = '0; rd_gnt = 1'b0; rd_data = '0;
    repeat (3) @(negedge clk);
    chk(pwm_out == 3'b000 && rd_req == 1'b0 && done == 1'b0, "R1", "reset state",
        int'({pwm_out, rd_req, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pwm_out == 3'b000 && rd_req == 1'b0 && done == 1'b0, "R1", "after release",
        int'({pwm_out, rd_req, done}), 0);

    // R2: one step, top 9, compare 4, polarity 0, divide by 2
    fill_mem(0, 0, 16);
    mem[0] = 16'h0004;
    run_seq(0, 1, 9, 0, 1, 0, 0, 0);
    chk(hi[0] == 8, "R2", "high cycles ch0", hi[0], 8);
    chk(n_cyc == 22, "R3", "directed run length", n_cyc, 22);

    // R8: compare above top, both polarities
    mem[10] = 16'h0014;
    run_seq(0, 0, 5, 10, 1, 1, 0, 0);
    chk(hi[1] == 5, "R8", "constant high", hi[1], 5);
    mem[10] = 16'h8014;
    run_seq(0, 0, 5, 10, 1, 1, 0, 0);
    chk(hi[2] == 0, "R8", "constant low", hi[2], 0);

    // R4 R5 R6 each mode, no stalls
    fill_mem(0, 4, 16); run_seq(0, 0, 7, 4, 5, 2, 0, 0);
    fill_mem(1, 6, 16); run_seq(1, 1, 6, 6, 6, 1, 0, 0);
    fill_mem(2, 8, 16); run_seq(2, 0, 0, 8, 8, 2, 0, 0);
    fill_mem(3, 2, 16); run_seq(3, 0, 4, 2, 3, 1, 0, 0);

    // R7: leftover words, stalled reads, three passes
    fill_mem(2, 12, 16); run_seq(2, 1, 0, 12, 6, 3, 1, 0);
    fill_mem(1, 20, 16); run_seq(1, 0, 3, 20, 5, 0, 1, 0);

    // R11: shorter than one record
    run_seq(1, 0, 3, 0, 1, 1, 0, 0);
    run_seq(0, 0, 3, 0, 0, 2, 0, 0);

    // R12: second start and config changes mid-run
    fill_mem(1, 0, 16); run_seq(1, 0, 5, 0, 4, 2, 1, 1);
    fill_mem(2, 4, 16); run_seq(2, 1, 0, 4, 8, 1, 0, 1);

    // random scenarios
    for (int i = 0; i < 14; i++) begin
      int mode  = $urandom % 4;
      int count = 1 + ($urandom % 12);
      int base  = $urandom % (64 - count);
      fill_mem(mode, base, 16);
      run_seq(mode, $urandom % 3, $urandom % 13, base, count, $urandom % 4,
              $urandom % 2, 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule